// File: doc/BRIEF.md
# UART Interrupt Priority Arbiter

This block gathers every interrupt cause of one serial channel and presents a single interrupt line plus an 8-bit status value. The status value names the most urgent cause that is both pending and enabled. Causes come from the neighbouring channel logic in two forms. The level-type causes are receive data available and receive timeout, which the block derives itself from the receive FIFO fill count and its own timeout counter. The pulse-type causes are line error, transmit holding empty, modem change, Xoff/special character and flow-pin change; each pulse sets a latched pending flag that stays set until its own clearing action.

The receive timeout counter lives inside the block. It counts 16x sample ticks while the receive FIFO holds data, and it fires after four character times. The character time follows the programmed frame format. The host clears causes through its read and write strobes. A status read removes only the cause shown in the value that was read, so the next read shows the next lower-priority cause.

Top module: `uart_irq_arbiter`

## Requirements
- R1: Status bits 5:0 encode the reported cause: 0x06 line error, 0x04 receive data, 0x0C receive timeout, 0x02 transmit empty, 0x00 modem change, 0x10 Xoff/special character, 0x20 flow-pin change, 0x01 when nothing is reported.
- R2: When several enabled causes are pending, the one reported is the first in this order: line error, receive data, receive timeout, transmit empty, modem change, Xoff/special, flow-pin change. Receive data and timeout share a level, and data is shown first.
- R3: Status bit 0 is 1 and `irq` is 0 exactly when no enabled cause is pending.
- R4: Status bits 7:6 both equal `fifo_en`.
- R5: A pulse on `isr_rd` clears the transmit-empty, Xoff or flow-pin cause only if that cause is the one shown in the status value at that edge. It has no effect on line-error or modem causes.
- R6: `lsr_rd` clears the line-error cause, `msr_rd` clears the modem cause, and `thr_wr` clears the transmit-empty cause.
- R7: With `fifo_en`=1, receive data is pending while `rx_count` >= `rx_trig` and stops once the count drops below. With `fifo_en`=0, it is pending while `rx_count` is non-zero.
- R8: Receive timeout becomes pending after 4 x 16 x B sample ticks with the FIFO non-empty, where B = 1 + (5 + `wlen`) + `par_en` + (`stop2` ? 2 : 1). It is never pending when `rx_count` is 0 or `fifo_en` is 0.
- R9: `stop_mid` and `rhr_rd` restart the timeout count, and `rhr_rd` removes a pending timeout.
- R10: Enable bits are en[0] receive data and timeout, en[1] transmit empty, en[2] line error, en[3] modem, en[4] Xoff/special, en[5] flow-pin. A disabled pulse-type cause stays latched without interrupting and is reported once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode active |
| en | input | 6 | Per-cause interrupt enables |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_trig | input | CNT_W (5) | Receive trigger level |
| wlen | input | 2 | Word length minus five |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| sample_tick | input | 1 | 16x bit-rate tick |
| stop_mid | input | 1 | Pulse at centre of a received stop bit |
| lsr_evt | input | 1 | Line error event pulse |
| thre_evt | input | 1 | Transmit holding empty event pulse |
| msr_evt | input | 1 | Modem input change event pulse |
| xoff_evt | input | 1 | Xoff/special character event pulse |
| flow_evt | input | 1 | Flow-pin change event pulse |
| isr_rd | input | 1 | Host read of the status value |
| lsr_rd | input | 1 | Host read of line status |
| msr_rd | input | 1 | Host read of modem status |
| rhr_rd | input | 1 | Host read of receive holding register |
| thr_wr | input | 1 | Host write of transmit holding register |
| irq | output | 1 | Interrupt request, registered |
| isr | output | 8 | Status value, registered |

## Verification
The bench pends all five pulse-type causes together and then peels them off one at a time. An arbiter with a wrong order, or one whose status read clears everything, would show the wrong next code or skip straight to idle. A status read while the modem cause is on display must leave that code in place, because a design that clears all shown causes would lose it. The timeout is probed just before and just after its threshold, for two frame formats, and after `rhr_rd` and `stop_mid` restarts. A counter with a fixed character time, or one that keeps its count through a restart, would fire early or late. An empty FIFO must never time out.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 7;
  localparam int NEN  = 6;

  // index order is report order (index 0 most urgent)
  typedef enum logic [2:0] {
    S_LSR  = 3'd0,
    S_RXD  = 3'd1,
    S_TOUT = 3'd2,
    S_THRE = 3'd3,
    S_MSR  = 3'd4,
    S_XOFF = 3'd5,
    S_FLOW = 3'd6
  } src_e;

  localparam logic [5:0] CODE_NONE = 6'h01;

  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      0:       return 6'h06;
      1:       return 6'h04;
      2:       return 6'h0C;
      3:       return 6'h02;
      4:       return 6'h00;
      5:       return 6'h10;
      default: return 6'h20;
    endcase
  endfunction

  function automatic int src_en_bit(input int idx);
    case (idx)
      0:       return 2;
      1, 2:    return 0;
      3:       return 1;
      4:       return 3;
      5:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int TICKS_PER_BIT = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       has_data,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       stop2,
  output logic       expired
);
  localparam int MAX_BITS = 12;
  localparam int TW = $clog2(TIMEOUT_CHARS * TICKS_PER_BIT * MAX_BITS + 1);
  localparam logic [TW-1:0] TICKS_PER_CHAR_BIT = TW'(TIMEOUT_CHARS * TICKS_PER_BIT);

  logic [3:0]    frame_bits;
  logic [TW-1:0] limit;
  logic [TW-1:0] cnt_q;

  always_comb begin
    frame_bits = 4'd6 + {2'b00, wlen} + {3'b000, par_en} + (stop2 ? 4'd2 : 4'd1);
    limit      = TICKS_PER_CHAR_BIT * TW'(frame_bits);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || !has_data || restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < limit)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= 1'b1;
      end else if (clr[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic            vld,
  output logic [2:0]      idx,
  output logic [5:0]      code
);
  always_comb begin
    vld  = 1'b0;
    idx  = 3'd0;
    code = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld  = 1'b1;
        idx  = 3'(i);
        code = src_code(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [NEN-1:0]   en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  input  logic             sample_tick,
  input  logic             stop_mid,
  input  logic             lsr_evt,
  input  logic             thre_evt,
  input  logic             msr_evt,
  input  logic             xoff_evt,
  input  logic             flow_evt,
  input  logic             isr_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  output logic             irq,
  output logic [7:0]       isr
);
  logic            has_data;
  logic            rxd_lvl;
  logic            tout_lvl;
  logic [NSRC-1:0] set_v, clr_v, flags, raw, req;
  logic            sel_vld;
  logic [2:0]      sel_idx;
  logic [5:0]      sel_code;
  logic            shown_vld_q;
  logic [2:0]      shown_idx_q;
  logic            clr_shown;

  assign has_data = (rx_count != '0);
  assign rxd_lvl  = fifo_en ? (rx_count >= rx_trig) : has_data;

  uart_irq_timeout #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .TIMEOUT_CHARS(TIMEOUT_CHARS)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .enable  (fifo_en),
    .has_data(has_data),
    .tick    (sample_tick),
    .restart (stop_mid || rhr_rd),
    .wlen    (wlen),
    .par_en  (par_en),
    .stop2   (stop2),
    .expired (tout_lvl)
  );

  assign clr_shown = isr_rd && shown_vld_q;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[S_LSR]  = lsr_evt;
    set_v[S_THRE] = thre_evt;
    set_v[S_MSR]  = msr_evt;
    set_v[S_XOFF] = xoff_evt;
    set_v[S_FLOW] = flow_evt;
    clr_v[S_LSR]  = lsr_rd;
    clr_v[S_MSR]  = msr_rd;
    clr_v[S_THRE] = thr_wr || (clr_shown && shown_idx_q == S_THRE);
    clr_v[S_XOFF] = clr_shown && shown_idx_q == S_XOFF;
    clr_v[S_FLOW] = clr_shown && shown_idx_q == S_FLOW;
  end

  uart_irq_flags #(.N(NSRC)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .set  (set_v),
    .clr  (clr_v),
    .flags(flags)
  );

  always_comb begin
    raw         = flags;
    raw[S_RXD]  = rxd_lvl;
    raw[S_TOUT] = tout_lvl;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign req[i] = raw[i] && en[src_en_bit(i)];
  end

  uart_irq_prio u_prio (
    .req (req),
    .vld (sel_vld),
    .idx (sel_idx),
    .code(sel_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr         <= {2'b00, CODE_NONE};
      irq         <= 1'b0;
      shown_vld_q <= 1'b0;
      shown_idx_q <= 3'd0;
    end else begin
      isr         <= {fifo_en, fifo_en, sel_code};
      irq         <= sel_vld;
      shown_vld_q <= sel_vld;
      shown_idx_q <= sel_idx;
    end
  end
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            fifo_en,
  input logic [NEN-1:0]  en,
  input logic [CW-1:0]   rx_count,
  input logic [CW-1:0]   rx_trig,
  input logic            isr_rd,
  input logic            xoff_evt,
  input logic            irq,
  input logic [7:0]      isr,
  input logic [NSRC-1:0] flags
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R3
  p_idle_code_r3: assert property (@(posedge clk) disable iff (rst || rst_d)
    !irq |-> isr[0]);

  // R4
  p_fifo_bits_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
    isr[7:6] == {2{$past(fifo_en)}});

  // R7
  p_rxd_trigger_r7: assert property (@(posedge clk) disable iff (rst || rst_d)
    (isr[5:0] == 6'h04) |-> $past(fifo_en ? (rx_count >= rx_trig) : (rx_count != '0)));

  // R8
  p_tout_nonempty_r8: assert property (@(posedge clk) disable iff (rst || rst_d)
    (isr[5:0] == 6'h0C) |-> ($past(rx_count, 2) != '0));

  // R5
  p_read_clears_xoff_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
    (isr_rd && isr[5:0] == 6'h10 && !xoff_evt) |=> !flags[S_XOFF]);

  // R10
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst || rst_d)
    irq |-> ($past(en) != '0));
endmodule

bind uart_irq_arbiter uart_irq_checker #(.CW(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fifo_en (fifo_en),
  .en      (en),
  .rx_count(rx_count),
  .rx_trig (rx_trig),
  .isr_rd  (isr_rd),
  .xoff_evt(xoff_evt),
  .irq     (irq),
  .isr     (isr),
  .flags   (flags)
);

// File: tb/tb_uart_irq_arbiter.sv
module tb_uart_irq_arbiter;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, par_en = 0, stop2 = 0, sample_tick = 0, stop_mid = 0;
  logic [5:0] en = '0;
  logic [CW-1:0] rx_count = '0, rx_trig = '0;
  logic [1:0] wlen = 2'd3;
  logic lsr_evt = 0, thre_evt = 0, msr_evt = 0, xoff_evt = 0, flow_evt = 0;
  logic isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic irq;
  logic [7:0] isr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_arbiter dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .en(en), .rx_count(rx_count),
    .rx_trig(rx_trig), .wlen(wlen), .par_en(par_en), .stop2(stop2),
    .sample_tick(sample_tick), .stop_mid(stop_mid), .lsr_evt(lsr_evt),
    .thre_evt(thre_evt), .msr_evt(msr_evt), .xoff_evt(xoff_evt),
    .flow_evt(flow_evt), .isr_rd(isr_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .rhr_rd(rhr_rd), .thr_wr(thr_wr), .irq(irq), .isr(isr)
  );

  // {fifo_en, en, rx_count, rx_trig, exp_isr, exp_irq}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 6'h00, 5'd0,  5'd0,  8'h01, 1'b0},
    {1'b0, 6'h01, 5'd0,  5'd0,  8'h01, 1'b0},
    {1'b0, 6'h01, 5'd1,  5'd0,  8'h04, 1'b1},
    {1'b1, 6'h01, 5'd3,  5'd4,  8'hC1, 1'b0},
    {1'b1, 6'h01, 5'd4,  5'd4,  8'hC4, 1'b1},
    {1'b1, 6'h00, 5'd4,  5'd4,  8'hC1, 1'b0},
    {1'b1, 6'h01, 5'd14, 5'd14, 8'hC4, 1'b1},
    {1'b1, 6'h01, 5'd13, 5'd14, 8'hC1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] e_isr, input logic e_irq);
    n_chk++;
    if (isr !== e_isr || irq !== e_irq) begin
      n_bad++;
      $display("FAIL %s: isr=%h irq=%b expected isr=%h irq=%b", tag, isr, irq, e_isr, e_irq);
    end
  endtask

  task automatic read_status;
    isr_rd = 1; step(1); isr_rd = 0; step(3);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R3 reset idle", 8'h01, 1'b0);

    for (int v = 0; v < NV; v++) begin
      fifo_en  = VEC[v][25];
      en       = VEC[v][24:19];
      rx_count = VEC[v][18:14];
      rx_trig  = VEC[v][13:9];
      step(3);
      chk($sformatf("R7/R4/R10 vector %0d", v), VEC[v][8:1], VEC[v][0]);
    end

    // priority walk-down
    rx_count = 0; rx_trig = 5'd4; fifo_en = 1; en = 6'h3F;
    lsr_evt = 1; thre_evt = 1; msr_evt = 1; xoff_evt = 1; flow_evt = 1;
    step(1);
    lsr_evt = 0; thre_evt = 0; msr_evt = 0; xoff_evt = 0; flow_evt = 0;
    step(3);
    chk("R2 line error first", 8'hC6, 1'b1);
    read_status;
    chk("R5 status read leaves line error", 8'hC6, 1'b1);
    lsr_rd = 1; step(1); lsr_rd = 0; step(3);
    chk("R6 lsr_rd clears, tx empty next", 8'hC2, 1'b1);
    read_status;
    chk("R5 status read clears tx empty", 8'hC0, 1'b1);
    read_status;
    chk("R5 status read leaves modem", 8'hC0, 1'b1);
    msr_rd = 1; step(1); msr_rd = 0; step(3);
    chk("R6 msr_rd clears, xoff next", 8'hD0, 1'b1);
    read_status;
    chk("R5 xoff cleared, flow next", 8'hE0, 1'b1);
    read_status;
    chk("R1 flow cleared, idle", 8'hC1, 1'b0);

    // holding write clears transmit empty
    thre_evt = 1; step(1); thre_evt = 0; step(3);
    chk("R1 tx empty code", 8'hC2, 1'b1);
    rx_count = 5'd4; step(3);
    chk("R2 rx data over tx empty", 8'hC4, 1'b1);
    rx_count = 5'd3; step(3);
    chk("R7 below trigger, tx empty shows", 8'hC2, 1'b1);
    thr_wr = 1; step(1); thr_wr = 0; step(3);
    chk("R6 thr_wr clears tx empty", 8'hC1, 1'b0);

    // enable mask
    en = 6'h2F;
    xoff_evt = 1; step(1); xoff_evt = 0; step(3);
    chk("R10 masked xoff silent", 8'hC1, 1'b0);
    en = 6'h3F; step(3);
    chk("R10 xoff shown once enabled", 8'hD0, 1'b1);
    read_status;
    chk("R5 xoff cleared", 8'hC1, 1'b0);

    // timeout, 8N1 -> 640 ticks
    rx_count = 0; rx_trig = 5'd8; en = 6'h01; wlen = 2'd3; par_en = 0; stop2 = 0;
    sample_tick = 1; step(2);
    rx_count = 5'd2;
    step(620);
    chk("R8 before 4 char times", 8'hC1, 1'b0);
    step(30);
    chk("R8 timeout code", 8'hCC, 1'b1);
    rhr_rd = 1; step(1); rhr_rd = 0; step(3);
    chk("R9 rhr_rd clears timeout", 8'hC1, 1'b0);
    step(600);
    chk("R9 count restarted by rhr_rd", 8'hC1, 1'b0);
    stop_mid = 1; step(1); stop_mid = 0;
    step(600);
    chk("R9 count restarted by stop_mid", 8'hC1, 1'b0);
    step(60);
    chk("R9 timeout after stop_mid restart", 8'hCC, 1'b1);
    rx_count = 0; step(3);
    chk("R8 empty removes timeout", 8'hC1, 1'b0);
    step(1000);
    chk("R8 empty never times out", 8'hC1, 1'b0);

    // 5 bits + parity + 2 stop -> 9 bits -> 576 ticks
    wlen = 2'd0; par_en = 1; stop2 = 1;
    rx_count = 5'd1; step(560);
    chk("R8 short frame before limit", 8'hC1, 1'b0);
    step(30);
    chk("R8 short frame timeout", 8'hCC, 1'b1);
    fifo_en = 0; en = 6'h01; step(3);
    chk("R8 non-FIFO shows rx data not timeout", 8'h04, 1'b1);
    rx_count = 0; step(1000);
    chk("R8 non-FIFO no timeout", 8'h01, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule